// File: doc/BRIEF.md
# Latched Three-Port Bus Exchanger

This block joins one 12-bit A port to two 12-bit B banks. In the B-to-A direction it places either bank on the A path, which lets two separate data paths share one. In the A-to-B direction it sends the A path to bank 1, to bank 2 or to both. Typical uses are splitting a multiplexed address/data bus and interleaving two memory banks.

Every path crosses its own level-sensitive storage latch, so there are four latches in total. A latch passes data while its enable is high. When the enable falls, the latch keeps the value it held at that moment. Each port has its own active-low output enable. A bus-hold keeper on every input keeps the last driven level when the input is released. The block has no clock. An active-low reset clears all keepers and latches.

Each bidirectional pin is modelled as three separate signals: an input value with a drive flag, an output value, and an output-enable.

Top module: `bus_xchg`

## Requirements
- R1: While rst_ni is low, every keeper and latch reads zero. An enabled output port therefore shows 0x000 whatever its inputs are.
- R2: While a path's latch enable is high, the latch is transparent. The enabled destination port follows the source port's current input.
- R3: When a latch enable falls, the latch captures its input. Later changes at that input do not reach the destination until the enable rises again.
- R4: bank_sel_i = 0 drives a_o from the bank-1-to-A latch. bank_sel_i = 1 drives it from the bank-2-to-A latch.
- R5: oe_n_b1_i and oe_n_b2_i act independently. A-side data can appear on bank 1 only, on bank 2 only, or on both.
- R6: A port whose oe_n is high drives 0 on its data output and 0 on its oe output. A port whose oe_n is low drives its oe output to 1.
- R7: While a port's drive flag is low, its keeper holds the last value received while the flag was high. Changes on the released input have no effect.
- R8: The two A-to-B latches are independent. One can hold while the other stays transparent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_ni | input | 1 | Active-low asynchronous clear of keepers and latches |
| a_i | input | 12 | A port input value |
| a_drv_i | input | 1 | A port input is driven (0 = released) |
| a_o | output | 12 | A port output value |
| a_oe_o | output | 1 | A port driver enable |
| b1_i | input | 12 | Bank 1 input value |
| b1_drv_i | input | 1 | Bank 1 input is driven |
| b1_o | output | 12 | Bank 1 output value |
| b1_oe_o | output | 1 | Bank 1 driver enable |
| b2_i | input | 12 | Bank 2 input value |
| b2_drv_i | input | 1 | Bank 2 input is driven |
| b2_o | output | 12 | Bank 2 output value |
| b2_oe_o | output | 1 | Bank 2 driver enable |
| en_b1a_i | input | 1 | Latch enable, bank 1 to A |
| en_b2a_i | input | 1 | Latch enable, bank 2 to A |
| en_ab1_i | input | 1 | Latch enable, A to bank 1 |
| en_ab2_i | input | 1 | Latch enable, A to bank 2 |
| bank_sel_i | input | 1 | Picks the bank latch that feeds A |
| oe_n_a_i | input | 1 | Active-low A output enable |
| oe_n_b1_i | input | 1 | Active-low bank 1 output enable |
| oe_n_b2_i | input | 1 | Active-low bank 2 output enable |

## Verification
All storage is level-sensitive, so a wrong keeper or latch value appears on an enabled output in the same settle time. No cycle delay hides it. A latch that keeps passing data after its enable falls shows up as soon as its source input changes. A keeper that does not hold shows up as soon as the released input changes. The bench therefore changes the data first and the enables second, and it compares every output against a model of all seven stored values after each change.

// File: rtl/bus_xchg_pkg.sv
package bus_xchg_pkg;
  localparam int unsigned XW = 12;
  localparam int unsigned N_BANK = 2;
endpackage

// File: rtl/xchg_keeper.sv
module xchg_keeper #(
  parameter int unsigned W = 12
) (
  input  logic         rst_ni,
  input  logic         drv_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  // last driven level survives a released input
  always_latch begin
    if (!rst_ni)    q_o = '0;
    else if (drv_i) q_o = d_i;
  end
endmodule

// File: rtl/xchg_latch.sv
module xchg_latch #(
  parameter int unsigned W = 12
) (
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  always_latch begin
    if (!rst_ni)   q_o = '0;
    else if (en_i) q_o = d_i;
  end
endmodule

// File: rtl/xchg_port_drv.sv
module xchg_port_drv #(
  parameter int unsigned W = 12
) (
  input  logic         oe_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o,
  output logic         oe_o
);
  assign oe_o = ~oe_ni;
  assign q_o  = oe_ni ? '0 : d_i;
endmodule

// File: rtl/bus_xchg.sv
module bus_xchg
  import bus_xchg_pkg::*;
#(
  parameter int unsigned W = XW
) (
  input  logic         rst_ni,
  input  logic [W-1:0] a_i,
  input  logic         a_drv_i,
  output logic [W-1:0] a_o,
  output logic         a_oe_o,
  input  logic [W-1:0] b1_i,
  input  logic         b1_drv_i,
  output logic [W-1:0] b1_o,
  output logic         b1_oe_o,
  input  logic [W-1:0] b2_i,
  input  logic         b2_drv_i,
  output logic [W-1:0] b2_o,
  output logic         b2_oe_o,
  input  logic         en_b1a_i,
  input  logic         en_b2a_i,
  input  logic         en_ab1_i,
  input  logic         en_ab2_i,
  input  logic         bank_sel_i,
  input  logic         oe_n_a_i,
  input  logic         oe_n_b1_i,
  input  logic         oe_n_b2_i
);
  localparam int unsigned NB = N_BANK;

  logic [W-1:0] a_keep;
  logic [W-1:0] b_in   [NB];
  logic         b_drv  [NB];
  logic [W-1:0] b_keep [NB];
  logic         en_ba  [NB];
  logic         en_ab  [NB];
  logic         b_oen  [NB];
  logic [W-1:0] ba_q   [NB];
  logic [W-1:0] ab_q   [NB];
  logic [W-1:0] b_out  [NB];
  logic         b_oe   [NB];
  logic [W-1:0] a_src;

  assign b_in[0]  = b1_i;      assign b_in[1]  = b2_i;
  assign b_drv[0] = b1_drv_i;  assign b_drv[1] = b2_drv_i;
  assign en_ba[0] = en_b1a_i;  assign en_ba[1] = en_b2a_i;
  assign en_ab[0] = en_ab1_i;  assign en_ab[1] = en_ab2_i;
  assign b_oen[0] = oe_n_b1_i; assign b_oen[1] = oe_n_b2_i;

  xchg_keeper #(.W(W)) u_keep_a (
    .rst_ni(rst_ni), .drv_i(a_drv_i), .d_i(a_i), .q_o(a_keep)
  );

  for (genvar g = 0; g < NB; g++) begin : g_bank
    xchg_keeper #(.W(W)) u_keep_b (
      .rst_ni(rst_ni), .drv_i(b_drv[g]), .d_i(b_in[g]), .q_o(b_keep[g])
    );
    xchg_latch #(.W(W)) u_lat_ba (
      .rst_ni(rst_ni), .en_i(en_ba[g]), .d_i(b_keep[g]), .q_o(ba_q[g])
    );
    xchg_latch #(.W(W)) u_lat_ab (
      .rst_ni(rst_ni), .en_i(en_ab[g]), .d_i(a_keep), .q_o(ab_q[g])
    );
    xchg_port_drv #(.W(W)) u_drv_b (
      .oe_ni(b_oen[g]), .d_i(ab_q[g]), .q_o(b_out[g]), .oe_o(b_oe[g])
    );
  end

  assign a_src = bank_sel_i ? ba_q[1] : ba_q[0];

  xchg_port_drv #(.W(W)) u_drv_a (
    .oe_ni(oe_n_a_i), .d_i(a_src), .q_o(a_o), .oe_o(a_oe_o)
  );

  assign b1_o = b_out[0];  assign b1_oe_o = b_oe[0];
  assign b2_o = b_out[1];  assign b2_oe_o = b_oe[1];

  // end-to-end checks across keeper, latch, mux and driver
  always_comb begin
    if (rst_ni) begin
      if (oe_n_a_i)
        p_quiet_a_r6: assert (a_o == '0 && !a_oe_o) else $error("disabled A drives");
      if (a_drv_i && en_ab1_i && !oe_n_b1_i)
        p_pass_ab1_r2: assert (b1_o == a_i) else $error("A->B1 not transparent");
      if (a_drv_i && en_ab2_i && !oe_n_b2_i)
        p_pass_ab2_r5: assert (b2_o == a_i) else $error("A->B2 not transparent");
      if (b1_drv_i && en_b1a_i && !bank_sel_i && !oe_n_a_i)
        p_sel_b1_r4: assert (a_o == b1_i) else $error("bank1 not on A");
      if (b2_drv_i && en_b2a_i && bank_sel_i && !oe_n_a_i)
        p_sel_b2_r4: assert (a_o == b2_i) else $error("bank2 not on A");
    end else begin
      if (!oe_n_a_i)
        p_rst_zero_r1: assert (a_o == '0) else $error("A nonzero in reset");
    end
  end
endmodule

// File: tb/tb_bus_xchg.sv
`timescale 1ns/1ps
module tb_bus_xchg;
  localparam int W = 12;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic         rst_ni;
  logic [W-1:0] a_i, b1_i, b2_i;
  logic         a_drv_i, b1_drv_i, b2_drv_i;
  logic [W-1:0] a_o, b1_o, b2_o;
  logic         a_oe_o, b1_oe_o, b2_oe_o;
  logic         en_b1a_i, en_b2a_i, en_ab1_i, en_ab2_i, bank_sel_i;
  logic         oe_n_a_i, oe_n_b1_i, oe_n_b2_i;

  bus_xchg #(.W(W)) dut (.*);

  int n_tests = 0;
  int n_fail = 0;
  bit done = 1'b0;

  // bench model of stored values
  logic [W-1:0] m_ka, m_k1, m_k2, m_l1a, m_l2a, m_la1, m_la2;

  task automatic model_upd();
    if (a_drv_i)  m_ka = a_i;
    if (b1_drv_i) m_k1 = b1_i;
    if (b2_drv_i) m_k2 = b2_i;
    if (en_b1a_i) m_l1a = m_k1;
    if (en_b2a_i) m_l2a = m_k2;
    if (en_ab1_i) m_la1 = m_ka;
    if (en_ab2_i) m_la2 = m_ka;
  endtask

  function automatic logic [W-1:0] exp_a();
    return oe_n_a_i ? '0 : (bank_sel_i ? m_l2a : m_l1a);
  endfunction
  function automatic logic [W-1:0] exp_b(input logic oen, input logic [W-1:0] l);
    return oen ? '0 : l;
  endfunction

  task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic chk_all(input string ta, input string tb1, input string tb2);
    chk(ta,  a_o,  exp_a());
    chk(tb1, b1_o, exp_b(oe_n_b1_i, m_la1));
    chk(tb2, b2_o, exp_b(oe_n_b2_i, m_la2));
    chk("R6 oe", {9'd0, a_oe_o, b1_oe_o, b2_oe_o},
        {9'd0, ~oe_n_a_i, ~oe_n_b1_i, ~oe_n_b2_i});
  endtask

  // data first, then enables, each settled before the next
  task automatic step(input logic [W-1:0] na, input logic [W-1:0] n1, input logic [W-1:0] n2,
                      input logic [2:0] drv, input logic [3:0] en,
                      input logic sel, input logic [2:0] oen);
    @(negedge clk);
    a_i = na; b1_i = n1; b2_i = n2;
    {a_drv_i, b1_drv_i, b2_drv_i} = drv;
    bank_sel_i = sel;
    {oe_n_a_i, oe_n_b1_i, oe_n_b2_i} = oen;
    #1 model_upd();
    {en_b1a_i, en_b2a_i, en_ab1_i, en_ab2_i} = en;
    #1 model_upd();
    #1;
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    rst_ni = 1'b0;
    a_i = 12'h7E1; b1_i = 12'h3C3; b2_i = 12'h999;
    {a_drv_i, b1_drv_i, b2_drv_i} = 3'b111;
    {en_b1a_i, en_b2a_i, en_ab1_i, en_ab2_i} = 4'b1111;
    bank_sel_i = 1'b0;
    {oe_n_a_i, oe_n_b1_i, oe_n_b2_i} = 3'b000;
    m_ka = '0; m_k1 = '0; m_k2 = '0; m_l1a = '0; m_l2a = '0; m_la1 = '0; m_la2 = '0;
    repeat (3) @(negedge clk);
    #1;
    // R1: cleared under reset with everything open
    chk("R1 a", a_o, '0);
    chk("R1 b1", b1_o, '0);
    chk("R1 b2", b2_o, '0);
    @(negedge clk);
    {en_b1a_i, en_b2a_i, en_ab1_i, en_ab2_i} = 4'b0000;
    #1 rst_ni = 1'b1;
    #1;
    chk_all("R1 a hold", "R1 b1 hold", "R1 b2 hold");

    // R2: transparency both directions
    step(12'h5A5, 12'h123, 12'hABC, 3'b111, 4'b1111, 1'b0, 3'b000);
    chk("R2 b1", b1_o, 12'h5A5);
    chk("R2 b2", b2_o, 12'h5A5);
    chk("R4 sel0", a_o, 12'h123);
    step(12'h5A5, 12'h123, 12'hABC, 3'b111, 4'b1111, 1'b1, 3'b000);
    chk("R4 sel1", a_o, 12'hABC);

    // R3 / R8: close A->B1 only, then move A
    step(12'h5A5, 12'h123, 12'hABC, 3'b111, 4'b1101, 1'b1, 3'b000);
    step(12'h0F0, 12'h123, 12'hABC, 3'b111, 4'b1101, 1'b1, 3'b000);
    chk("R3 b1 held", b1_o, 12'h5A5);
    chk("R8 b2 open", b2_o, 12'h0F0);
    // R3: close B2->A, change bank 2
    step(12'h0F0, 12'h123, 12'hABC, 3'b111, 4'b1001, 1'b1, 3'b000);
    step(12'h0F0, 12'h123, 12'h444, 3'b111, 4'b1001, 1'b1, 3'b000);
    chk("R3 a held", a_o, 12'hABC);

    // R5 / R6: per-bank enables
    step(12'h0F0, 12'h123, 12'h444, 3'b111, 4'b1001, 1'b1, 3'b010);
    chk("R6 b1 off", b1_o, '0);
    chk("R6 b1 oe", {11'd0, b1_oe_o}, 12'd0);
    chk("R5 b2 on", b2_o, 12'h0F0);
    step(12'h0F0, 12'h123, 12'h444, 3'b111, 4'b1001, 1'b1, 3'b101);
    chk("R5 b1 on", b1_o, 12'h5A5);
    chk("R6 a off", a_o, '0);
    chk("R6 b2 off", b2_o, '0);

    // R7: release A, wiggle it; transparent B2 path must keep last value
    step(12'h0F0, 12'h123, 12'h444, 3'b011, 4'b1001, 1'b1, 3'b000);
    step(12'hFFF, 12'h123, 12'h444, 3'b011, 4'b1001, 1'b1, 3'b000);
    chk("R7 keep a", b2_o, 12'h0F0);
    step(12'hFFF, 12'h777, 12'h444, 3'b001, 4'b1001, 1'b0, 3'b000);
    chk("R7 keep b1", a_o, 12'h123);

    // constrained random, fixed seed
    void'($urandom(32'd4242));
    for (int i = 0; i < 400; i++) begin
      step(W'($urandom), W'($urandom), W'($urandom),
           3'($urandom | 32'(($urandom % 4) != 0 ? 3'b111 : 3'b000)),
           4'($urandom), 1'($urandom), 3'($urandom));
      chk_all("R4 rand a", "R5 rand b1", "R8 rand b2");
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule